// File: doc/BRIEF.md
# Floating-Point Fractional Part Extractor

This unit takes one IEEE-754 binary floating-point operand and returns the part of its value that lies after the binary point, x − trunc(x). The result keeps the operand's sign. It is computed exactly, so no rounding increment is ever applied. The field widths are parameters: the defaults give single precision, and setting `EXP_W=11, MAN_W=52` gives double precision with bias 1023. Each operand is accepted with a valid strobe. One clock later the unit presents a registered result together with four per-operation exception flags: invalid, denormal, underflow and inexact.

The result is chosen by classifying the operand.
- NaNs and infinities get special handling.
- Operands too large to carry fraction bits give zero.
- Operands below one in magnitude pass through unchanged, apart from the subnormal rules.
- Any other operand has its integer bits masked away, and the remainder is renormalised with a leading-zero count and a barrel shift.

The rounding-mode input matters in only one way: it selects the sign of a zero that comes from an integral value. Two inputs control subnormal operands: denormals-are-zero and flush-to-zero. An underflow mask input decides whether a subnormal operand also reports underflow.

Top module: `frc_unit`

## Requirements
- R1: An operand with exponent all ones and a non-zero mantissa returns the same sign, exponent and low mantissa bits, with the mantissa MSB (quiet bit) forced to 1. Invalid is raised only when that MSB was 0 in the operand.
- R2: An infinity of either sign returns the default NaN (sign 1, exponent all ones, mantissa MSB 1, other bits 0; 0xFFC00000 in single precision) and raises invalid.
- R3: A finite operand whose biased exponent is at least bias+MAN_W (150 in single precision) returns a zero whose sign bit is 1 only when the rounding mode is round-down. The rounding-mode encoding is 00 nearest-even, 01 down, 10 up, 11 toward zero.
- R4: A normal operand with biased exponent below the bias (magnitude under 1.0) is returned unchanged with no flags.
- R5: A zero operand of either sign, or a subnormal operand while denormals-are-zero is 1, returns the round-down-signed zero of R3 with no flags.
- R6: A subnormal operand with denormals-are-zero 0 and flush-to-zero 0 is returned unchanged. It raises denormal, and it raises underflow exactly when the underflow mask input is 0.
- R7: A subnormal operand with denormals-are-zero 0 and flush-to-zero 1 returns a zero with the operand's sign. It raises denormal, underflow and inexact.
- R8: An operand with biased exponent from the bias up to bias+MAN_W−1 that is not integral returns exactly x − trunc(x) as a normal number with the operand's sign and no flags. Its magnitude is below 1.0.
- R9: An operand in the exponent range of R8 whose value is integral returns the round-down-signed zero of R3.
- R10: The result and flags appear one clock after an accepted operand, and out_valid is high in exactly that cycle. Synchronous reset clears out_valid, the result and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 1+EXP_W+MAN_W | Floating-point operand |
| in_rmode | input | 2 | Rounding mode (00 nearest, 01 down, 10 up, 11 zero) |
| in_daz | input | 1 | Treat subnormal operands as zero |
| in_ftz | input | 1 | Flush subnormal results to zero |
| in_unf_mask | input | 1 | Underflow mask (1 = masked) |
| out_valid | output | 1 | Result strobe |
| out_result | output | 1+EXP_W+MAN_W | Fractional part |
| out_invalid | output | 1 | Invalid operation flag |
| out_denormal | output | 1 | Subnormal operand flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Two functions can act in the same cycle: the subnormal-operand reporting and the flush-to-zero replacement. When flush-to-zero is on and underflow is unmasked, both want to raise underflow, while the denormal flag and the replacement zero's sign must still be correct. Denormals-are-zero overrides both of them. The bench provokes this by applying all eight combinations of the three control bits to the smallest and the largest subnormal of each sign. It judges every flag and the result bit-for-bit against a behavioural model. The sign-of-zero choice under each rounding mode is driven through the same comparison.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_NAN      = 3'd0,
    CL_INF      = 3'd1,
    CL_INTEGRAL = 3'd2,
    CL_ZERO     = 3'd3,
    CL_SUBN     = 3'd4,
    CL_TINY     = 3'd5,
    CL_MIXED    = 3'd6
  } opclass_e;

  typedef struct packed {
    logic invalid;
    logic denormal;
    logic underflow;
    logic inexact;
  } fflags_t;

endpackage

// File: rtl/frc_classify.sv
module frc_classify
  import frc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] operand,
  output logic                 sign,
  output logic [EXP_W-1:0]     expo,
  output logic [MAN_W-1:0]     man,
  output opclass_e             cls
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_INT = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  assign sign = operand[EXP_W+MAN_W];
  assign expo = operand[EXP_W+MAN_W-1:MAN_W];
  assign man  = operand[MAN_W-1:0];

  always_comb begin
    if (expo == EXP_TOP)      cls = (man != '0) ? CL_NAN : CL_INF;
    else if (expo >= EXP_INT) cls = CL_INTEGRAL;
    else if (expo == '0)      cls = (man != '0) ? CL_SUBN : CL_ZERO;
    else if (expo < EXP_ONE)  cls = CL_TINY;
    else                      cls = CL_MIXED;
  end
endmodule

// File: rtl/frc_remainder.sv
module frc_remainder #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] man,
  output logic [MAN_W-1:0] rem
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  // Mantissa bit i carries weight 2^(expo-BIAS-MAN_W+i); it is fractional
  // exactly when expo < BIAS+MAN_W-i, so each bit gets a constant compare.
  for (genvar i = 0; i < MAN_W; i++) begin : g_keep
    localparam logic [EXP_W-1:0] CUT = EXP_W'(BIAS + MAN_W - i);
    assign rem[i] = man[i] & (expo < CUT);
  end
endmodule

// File: rtl/frc_lzc.sv
module frc_lzc #(
  parameter int W = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] lz,
  output logic          zero
);
  always_comb begin
    lz = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) lz = CW'(W - 1 - i);
    end
  end

  assign zero = ~|vec;
endmodule

// File: rtl/frc_normalize.sv
module frc_normalize #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0] expo,
  input  logic [MAN_W-1:0] rem,
  output logic [EXP_W-1:0] n_exp,
  output logic [MAN_W-1:0] n_man,
  output logic             is_zero
);
  localparam int CW = $clog2(MAN_W + 1);

  logic [CW-1:0]    lz;
  logic [MAN_W-1:0] stage [CW+1];

  frc_lzc #(.W(MAN_W)) u_lzc (
    .vec  (rem),
    .lz   (lz),
    .zero (is_zero)
  );

  assign stage[0] = rem;
  for (genvar k = 0; k < CW; k++) begin : g_shift
    assign stage[k+1] = lz[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  // Leading one now sits in the MSB; it becomes the hidden bit.
  assign n_man = {stage[CW][MAN_W-2:0], 1'b0};
  assign n_exp = expo - EXP_W'(lz) - EXP_W'(1);
endmodule

// File: rtl/frc_unit.sv
module frc_unit
  import frc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_operand,
  input  logic [1:0]   in_rmode,
  input  logic         in_daz,
  input  logic         in_ftz,
  input  logic         in_unf_mask,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_invalid,
  output logic         out_denormal,
  output logic         out_underflow,
  output logic         out_inexact
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_INT = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;
  localparam logic [W-1:0] DEF_NAN = {1'b1, EXP_TOP, 1'b1, {(MAN_W-1){1'b0}}};

  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  opclass_e         cls;
  logic [MAN_W-1:0] rem;
  logic [EXP_W-1:0] n_exp;
  logic [MAN_W-1:0] n_man;
  logic             rem_zero;
  logic [W-1:0]     res_d;
  fflags_t          flg_d;
  logic [W-1:0]     rd_zero;

  frc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .operand (in_operand),
    .sign    (sign),
    .expo    (expo),
    .man     (man),
    .cls     (cls)
  );

  frc_remainder #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rem (
    .expo (expo),
    .man  (man),
    .rem  (rem)
  );

  frc_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .expo    (expo),
    .rem     (rem),
    .n_exp   (n_exp),
    .n_man   (n_man),
    .is_zero (rem_zero)
  );

  assign rd_zero = {(rmode_e'(in_rmode) == RM_DOWN), {(W-1){1'b0}}};

  always_comb begin
    flg_d = '0;
    res_d = in_operand;
    unique case (cls)
      CL_NAN: begin
        res_d = {sign, EXP_TOP, 1'b1, man[MAN_W-2:0]};
        flg_d.invalid = ~man[MAN_W-1];
      end
      CL_INF: begin
        res_d = DEF_NAN;
        flg_d.invalid = 1'b1;
      end
      CL_INTEGRAL, CL_ZERO: res_d = rd_zero;
      CL_TINY:              res_d = in_operand;
      CL_SUBN: begin
        if (in_daz) begin
          res_d = rd_zero;
        end else begin
          flg_d.denormal  = 1'b1;
          flg_d.underflow = ~in_unf_mask;
          if (in_ftz) begin
            flg_d.underflow = 1'b1;
            flg_d.inexact   = 1'b1;
            res_d = {sign, {(W-1){1'b0}}};
          end
        end
      end
      CL_MIXED: res_d = rem_zero ? rd_zero : {sign, n_exp, n_man};
      default:  res_d = in_operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_invalid   <= 1'b0;
      out_denormal  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= res_d;
        out_invalid   <= flg_d.invalid;
        out_denormal  <= flg_d.denormal;
        out_underflow <= flg_d.underflow;
        out_inexact   <= flg_d.inexact;
      end
    end
  end

  AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand[W-2:MAN_W] == EXP_TOP && in_operand[MAN_W-1:0] != '0)
    |=> (out_result[W-2:MAN_W-1] == {EXP_TOP, 1'b1}
         && out_result[MAN_W-2:0] == $past(in_operand[MAN_W-2:0]))); // R1

  AST_INF_DEFAULT_NAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand[W-2:MAN_W] == EXP_TOP && in_operand[MAN_W-1:0] == '0)
    |=> (out_invalid && out_result == DEF_NAN)); // R2

  AST_INTEGRAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand[W-2:MAN_W] >= EXP_INT && in_operand[W-2:MAN_W] != EXP_TOP)
    |=> (out_result[W-2:0] == '0 && out_result[W-1] == ($past(in_rmode) == 2'b01))); // R3

  AST_NORMAL_NO_SUBN_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand[W-2:MAN_W] != '0)
    |=> (!out_denormal && !out_underflow && !out_inexact)); // R6

  AST_FRAC_BELOW_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand[W-2:MAN_W] >= EXP_ONE && in_operand[W-2:MAN_W] < EXP_INT)
    |=> (out_result[W-2:MAN_W] < EXP_ONE)); // R8

  AST_OUT_VALID_TIMING: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid)); // R10
endmodule

// File: tb/frc_unit_tb.sv
module frc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_daz = 1'b0;
  logic        in_ftz = 1'b0;
  logic        in_unf_mask = 1'b1;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid, out_denormal, out_underflow, out_inexact;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit running  = 0;

  logic [35:0] exp_q [$];
  string       req_q [$];
  logic [31:0] op_q  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frc_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_rmode(in_rmode), .in_daz(in_daz), .in_ftz(in_ftz),
    .in_unf_mask(in_unf_mask), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_denormal(out_denormal),
    .out_underflow(out_underflow), .out_inexact(out_inexact)
  );

  // Behavioural model: value arithmetic on integers, flags {inv,dn,uf,ix}.
  function automatic void ref_model(input logic [31:0] x, input logic [1:0] rm,
                                    input logic daz, input logic ftz, input logic um,
                                    output logic [35:0] ev, output string req);
    logic        s = x[31];
    int          e = int'(x[30:23]);
    logic [22:0] f = x[22:0];
    logic [31:0] rdz = {(rm == 2'b01), 31'b0};
    logic [31:0] res;
    logic inv = 0, dn = 0, uf = 0, ix = 0;
    longint whole, frac;
    int     be;
    if (e == 255) begin
      if (f != 0) begin res = {s, 8'hFF, 1'b1, f[21:0]}; inv = !f[22]; req = "R1"; end
      else begin res = 32'hFFC0_0000; inv = 1; req = "R2"; end
    end else if (e == 0) begin
      if (f == 0 || daz) begin res = rdz; req = "R5"; end
      else begin
        dn = 1;
        if (ftz) begin uf = 1; ix = 1; res = {s, 31'b0}; req = "R7"; end
        else begin uf = !um; res = x; req = "R6"; end
      end
    end else if (e < 127) begin
      res = x; req = "R4";
    end else if (e >= 150) begin
      res = rdz; req = "R3";
    end else begin
      whole = longint'({1'b1, f});
      frac  = whole % (64'sd1 <<< (150 - e));
      if (frac == 0) begin res = rdz; req = "R9"; end
      else begin
        be = e;
        while (frac < 64'sd8388608) begin frac = frac <<< 1; be = be - 1; end
        res = {s, 8'(be), frac[22:0]};
        req = "R8";
      end
    end
    ev = {inv, dn, uf, ix, res};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] x, input logic [1:0] rm,
                      input logic daz, input logic ftz, input logic um);
    logic [35:0] ev;
    string r;
    @(negedge clk);
    in_valid = 1; in_operand = x; in_rmode = rm;
    in_daz = daz; in_ftz = ftz; in_unf_mask = um;
    ref_model(x, rm, daz, ftz, um, ev, r);
    exp_q.push_back(ev); req_q.push_back(r); op_q.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // Per-clock comparison, sampled one time unit after the edge.
  always @(posedge clk) begin
    logic        v_seen;
    logic [35:0] ev, got;
    string       r;
    logic [31:0] op;
    v_seen = in_valid;
    #1;
    if (running) begin
      checks++;
      if (out_valid !== v_seen) begin
        fails++;
        $display("FAIL R10 out_valid: got %b expected %b", out_valid, v_seen);
      end
      if (out_valid && exp_q.size() > 0) begin
        ev = exp_q.pop_front(); r = req_q.pop_front(); op = op_q.pop_front();
        got = {out_invalid, out_denormal, out_underflow, out_inexact, out_result};
        checks++;
        if (got !== ev) begin
          fails++;
          $display("FAIL %s op=%h: got flags=%b res=%h expected flags=%b res=%h",
                   r, op, got[35:32], got[31:0], ev[35:32], ev[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if ({out_valid, out_result, out_invalid, out_denormal, out_underflow, out_inexact} !== '0) begin
      fails++;
      $display("FAIL R10 reset: got valid=%b res=%h expected 0 0", out_valid, out_result);
    end
    rst = 0;
    running = 1;
    // R5 zeros, each rounding mode
    for (int m = 0; m < 4; m++) begin
      send(32'h0000_0000, 2'(m), 0, 0, 1);
      send(32'h8000_0000, 2'(m), 0, 0, 1);
    end
    // R9 / R3 integral values
    send(32'h3F80_0000, 2'b00, 0, 0, 1);
    send(32'hBF80_0000, 2'b01, 0, 0, 1);
    send(32'h4B00_0000, 2'b01, 0, 0, 1);
    send(32'hCB00_0000, 2'b10, 0, 0, 1);
    send(32'h7F7F_FFFF, 2'b11, 0, 0, 1);
    // R8 mixed values
    send(32'h3FC0_0000, 2'b00, 0, 0, 1);
    send(32'h4AFF_FFFF, 2'b00, 0, 0, 1);
    send(32'hC030_0000, 2'b01, 0, 0, 1);
    send(32'h3FFF_FFFF, 2'b00, 0, 0, 1);
    // R4 tiny normals
    send(32'h3F7F_FFFF, 2'b00, 0, 0, 1);
    send(32'h8080_0000, 2'b01, 1, 1, 0);
    idle();
    // R1 / R2 specials
    send(32'h7F80_0000, 2'b00, 0, 0, 1);
    send(32'hFF80_0000, 2'b00, 0, 0, 1);
    send(32'h7FC0_0001, 2'b00, 0, 0, 1);
    send(32'h7F80_0001, 2'b00, 0, 0, 1);
    send(32'hFFA0_1234, 2'b10, 0, 0, 1);
    idle();
    idle();
    // R5 R6 R7: subnormals against every control combination
    for (int c = 0; c < 8; c++) begin
      send(32'h0000_0001, 2'b01, c[2], c[1], c[0]);
      send(32'h807F_FFFF, 2'b00, c[2], c[1], c[0]);
      send(32'h007F_FFFF, 2'b01, c[2], c[1], c[0]);
      send(32'h8000_0001, 2'b11, c[2], c[1], c[0]);
    end
    // Random operands, biased toward the fractional range
    for (int n = 0; n < 400; n++) begin
      logic [31:0] x;
      x = $urandom;
      if (n % 2 == 0) x[30:23] = 8'(127 + ($urandom % 24));
      send(x, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (n % 37 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 pending results: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule